// File: doc/BRIEF.md
# Bit-Tree Identifier Lookup Engine

This block turns a 12-bit peripheral identifier into an 8-bit channel index by walking a compressed binary decision tree held in a local node table. The identifier is built from a 4-bit slave id in its upper bits and an 8-bit peripheral number in its lower bits. Each table node names one identifier bit to test. For each value of that bit, the node either points to another node or gives the final answer.

A host first loads the node table through a simple write port. It then pulses `start` with an identifier. The engine reads one node per clock cycle, starting at node 0. It finishes with a one-cycle `done` pulse that carries a found/not-found status and the 8-bit result. Walks that run too deep, or that point outside the table, end as not-found.

Top module: `idtree_lookup`

## Requirements
- R1: While reset is held, and after its release, `busy`, `done`, `found` and `result` are all 0.
- R2: When `start` is high while the engine is idle, it captures the identifier `{slave_id, periph_num}` (slave id in bits 11:8) and begins at node 0. `busy` is high from the next cycle.
- R3: Node bits 21:18 pick the identifier bit to test. Selector values 12 to 15 always test as 0. Node bits 31:22 are ignored.
- R4: If the tested bit is 0, node bit 17 is the continue flag and bits 16:9 are the payload. If the tested bit is 1, node bit 8 is the continue flag and bits 7:0 are the payload.
- R5: With the continue flag set, the payload is the next node index. With it clear, the walk ends with `found`=1 and `result` equal to the payload.
- R6: One node is examined per cycle. `done` rises exactly k cycles after the cycle in which `start` was accepted, where k is the number of nodes examined.
- R7: A walk examines at most 16 nodes. If the 16th node still says continue, the walk ends after 16 cycles with `found`=0 and `result`=0.
- R8: The table holds nodes 0 to 254. Reaching index 255 costs one cycle and ends the walk with `found`=0 and `result`=0.
- R9: `done` is a single-cycle pulse, and `busy` is low in that cycle. `found` and `result` keep their values until the next accepted start.
- R10: A `start` that arrives while `busy` is high is ignored. The running walk finishes with the result and timing of its original identifier.
- R11: When `tbl_we` is high, node `tbl_waddr` takes `tbl_wdata` at the clock edge. A write to address 255 changes no node.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a lookup (accepted only when idle) |
| slave_id | input | 4 | Slave id, identifier bits 11:8 |
| periph_num | input | 8 | Peripheral number, identifier bits 7:0 |
| tbl_we | input | 1 | Node table write enable |
| tbl_waddr | input | 8 | Node index to write |
| tbl_wdata | input | 32 | Node word to write |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Walk ended on a leaf |
| result | output | 8 | Channel index (0 when not found) |

## Verification
The bench sets up a tree with two walks that both reach a 16th node. In one, the 16th node is a leaf. In the other, it says continue and points to a leaf at node 31. An off-by-one in the depth limit would either reject the first walk or accept a 17th step and return 0x99.

Other cases target specific faults:
- A walk that reaches child index 255 would return stale data if the range check were missing.
- A node with selector 13 catches a design that reads a non-existent identifier bit.
- Garbage placed in node bits 31:22, together with different flags on each branch, exposes swapped or shifted fields.
- A second `start` issued mid-walk would corrupt the result or the latency if it were not ignored.
- Table rewrites, including a write to address 255, show whether writes land where they should.

// File: rtl/idtree_pkg.sv
package idtree_pkg;

  // Node word field positions (the decoder depends on these)
  localparam int SEL_HI     = 21;
  localparam int SEL_LO     = 18;
  localparam int SEL_W      = SEL_HI - SEL_LO + 1;
  localparam int ZERO_CONT  = 17;
  localparam int ZERO_PAY_HI = 16;
  localparam int ZERO_PAY_LO = 9;
  localparam int ONE_CONT   = 8;
  localparam int ONE_PAY_HI = 7;
  localparam int ONE_PAY_LO = 0;
  localparam int PAY_W      = ONE_PAY_HI - ONE_PAY_LO + 1;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } walk_state_e;

endpackage

// File: rtl/idtree_table.sv
module idtree_table #(
  parameter int ENTRIES = 255,
  parameter int IDX_W   = 8,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_hit,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] nodes [ENTRIES];
  logic              wr_hit;

  assign wr_hit = (int'(wr_idx) < ENTRIES);
  assign rd_hit = (int'(rd_idx) < ENTRIES);

  always_ff @(posedge clk) begin
    if (wr_en && wr_hit) begin
      nodes[wr_idx] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_hit) begin
      rd_data = nodes[rd_idx];
    end
  end

endmodule

// File: rtl/idtree_decode.sv
module idtree_decode
  import idtree_pkg::*;
#(
  parameter int ID_W   = 12,
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] node,
  input  logic [ID_W-1:0]   ident,
  output logic              go_on,
  output logic [PAY_W-1:0]  payload
);

  localparam int SPAN = 1 << SEL_W;

  logic [SPAN-1:0]  id_pad;
  logic [SEL_W-1:0] sel;
  logic             tested;

  // Identifier bits above ID_W read as zero
  assign id_pad = SPAN'(ident);
  assign sel    = node[SEL_HI:SEL_LO];
  assign tested = id_pad[sel];

  always_comb begin
    if (tested) begin
      go_on   = node[ONE_CONT];
      payload = node[ONE_PAY_HI:ONE_PAY_LO];
    end else begin
      go_on   = node[ZERO_CONT];
      payload = node[ZERO_PAY_HI:ZERO_PAY_LO];
    end
  end

endmodule

// File: rtl/idtree_walker.sv
module idtree_walker
  import idtree_pkg::*;
#(
  parameter int ID_W      = 12,
  parameter int IDX_W     = 8,
  parameter int MAX_STEPS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ID_W-1:0]  ident_in,
  input  logic             node_hit,
  input  logic             node_go_on,
  input  logic [PAY_W-1:0] node_payload,
  output logic [IDX_W-1:0] node_idx,
  output logic [ID_W-1:0]  walk_id,
  output logic             busy,
  output logic             done,
  output logic             found,
  output logic [PAY_W-1:0] result
);

  localparam int STEP_W = $clog2(MAX_STEPS + 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(MAX_STEPS - 1);

  walk_state_e      state_q, state_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic [STEP_W-1:0] steps_q, steps_n;
  logic [ID_W-1:0]  id_q, id_n;
  logic [PAY_W-1:0] res_q, res_n;
  logic             found_q, found_n;
  logic             done_q, done_n;
  logic             upd_en;

  assign upd_en = (state_q == ST_WALK) || start;

  always_comb begin
    state_n = state_q;
    idx_n   = idx_q;
    steps_n = steps_q;
    id_n    = id_q;
    res_n   = res_q;
    found_n = found_q;
    done_n  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_n = ST_WALK;
          idx_n   = '0;
          steps_n = '0;
          id_n    = ident_in;
          res_n   = '0;
          found_n = 1'b0;
        end
      end
      ST_WALK: begin
        if (!node_hit) begin
          state_n = ST_IDLE;
          done_n  = 1'b1;
          found_n = 1'b0;
          res_n   = '0;
        end else if (!node_go_on) begin
          state_n = ST_IDLE;
          done_n  = 1'b1;
          found_n = 1'b1;
          res_n   = node_payload;
        end else if (steps_q == LAST_STEP) begin
          state_n = ST_IDLE;
          done_n  = 1'b1;
          found_n = 1'b0;
          res_n   = '0;
        end else begin
          idx_n   = IDX_W'(node_payload);
          steps_n = steps_q + 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      done_q  <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      steps_q <= '0;
      id_q    <= '0;
      res_q   <= '0;
      found_q <= 1'b0;
    end else if (upd_en) begin
      idx_q   <= idx_n;
      steps_q <= steps_n;
      id_q    <= id_n;
      res_q   <= res_n;
      found_q <= found_n;
    end
  end

  assign node_idx = idx_q;
  assign walk_id  = id_q;
  assign busy     = (state_q == ST_WALK);
  assign done     = done_q;
  assign found    = found_q;
  assign result   = res_q;

endmodule

// File: rtl/idtree_lookup.sv
module idtree_lookup
  import idtree_pkg::*;
#(
  parameter int SID_W     = 4,
  parameter int PNUM_W    = 8,
  parameter int IDX_W     = 8,
  parameter int ENTRY_W   = 32,
  parameter int ENTRIES   = 255,
  parameter int MAX_STEPS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [SID_W-1:0]   slave_id,
  input  logic [PNUM_W-1:0]  periph_num,
  input  logic               tbl_we,
  input  logic [IDX_W-1:0]   tbl_waddr,
  input  logic [ENTRY_W-1:0] tbl_wdata,
  output logic               busy,
  output logic               done,
  output logic               found,
  output logic [PAY_W-1:0]   result
);

  localparam int ID_W = SID_W + PNUM_W;

  logic [1:0]         rst_pipe;
  logic               core_rst_n;
  logic [ID_W-1:0]    ident;
  logic [ID_W-1:0]    walk_id;
  logic [IDX_W-1:0]   node_idx;
  logic               node_hit;
  logic [ENTRY_W-1:0] node_word;
  logic               node_go_on;
  logic [PAY_W-1:0]   node_payload;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign core_rst_n = rst_pipe[1];

  assign ident = {slave_id, periph_num};

  idtree_table #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W),
    .DATA_W  (ENTRY_W)
  ) u_table (
    .clk     (clk),
    .wr_en   (tbl_we),
    .wr_idx  (tbl_waddr),
    .wr_data (tbl_wdata),
    .rd_idx  (node_idx),
    .rd_hit  (node_hit),
    .rd_data (node_word)
  );

  idtree_decode #(
    .ID_W   (ID_W),
    .DATA_W (ENTRY_W)
  ) u_decode (
    .node    (node_word),
    .ident   (walk_id),
    .go_on   (node_go_on),
    .payload (node_payload)
  );

  idtree_walker #(
    .ID_W      (ID_W),
    .IDX_W     (IDX_W),
    .MAX_STEPS (MAX_STEPS)
  ) u_walker (
    .clk          (clk),
    .rst_n        (core_rst_n),
    .start        (start),
    .ident_in     (ident),
    .node_hit     (node_hit),
    .node_go_on   (node_go_on),
    .node_payload (node_payload),
    .node_idx     (node_idx),
    .walk_id      (walk_id),
    .busy         (busy),
    .done         (done),
    .found        (found),
    .result       (result)
  );

endmodule

// File: rtl/idtree_lookup_chk.sv
module idtree_lookup_chk #(
  parameter int MAX_STEPS = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       found,
  input logic [7:0] result
);

  localparam int CNT_W = $clog2(MAX_STEPS + 2);

  logic [CNT_W-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
    end else if (busy) begin
      busy_cnt <= busy_cnt + 1'b1;
    end else begin
      busy_cnt <= '0;
    end
  end

  // R7: a walk never stays busy longer than the step limit
  p_depth_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(busy_cnt) <= MAX_STEPS);

  // R7, R8: a not-found completion reports result 0
  p_notfound_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !found) |-> (result == 8'h00));

  // R9: busy is low while done is high
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9: done lasts one cycle
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: a walk only ends through a done pulse
  p_busy_falls_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R9: outputs hold while idle
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> ($stable(result) && $stable(found)));

  // R2: an idle start makes the engine busy
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !done && $past(rst_n)) |=> busy);

endmodule

bind idtree_lookup idtree_lookup_chk #(.MAX_STEPS(MAX_STEPS)) u_chk (
  .clk    (clk),
  .rst_n  (core_rst_n),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .found  (found),
  .result (result)
);

// File: tb/tb_idtree_lookup.sv
`timescale 1ns/1ps
module tb_idtree_lookup;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [3:0]  slave_id;
  logic [7:0]  periph_num;
  logic        tbl_we;
  logic [7:0]  tbl_waddr;
  logic [31:0] tbl_wdata;
  logic        busy;
  logic        done;
  logic        found;
  logic [7:0]  result;

  int n_checks = 0;
  int n_fail   = 0;

  idtree_lookup dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .slave_id   (slave_id),
    .periph_num (periph_num),
    .tbl_we     (tbl_we),
    .tbl_waddr  (tbl_waddr),
    .tbl_wdata  (tbl_wdata),
    .busy       (busy),
    .done       (done),
    .found      (found),
    .result     (result)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {id[11:0], found, result[7:0], cycles[4:0]}
  localparam logic [25:0] VECS [8] = '{
    {12'h800, 1'b1, 8'hA5, 5'd1},
    {12'h000, 1'b1, 8'h10, 5'd2},
    {12'h001, 1'b1, 8'h33, 5'd4},
    {12'h101, 1'b0, 8'h00, 5'd6},
    {12'h103, 1'b1, 8'h5C, 5'd16},
    {12'h10B, 1'b0, 8'h00, 5'd16},
    {12'h700, 1'b1, 8'h10, 5'd2},
    {12'h9FF, 1'b1, 8'hA5, 5'd1}
  };

  function automatic logic [31:0] mk(input int sel, input bit c0, input int p0,
                                     input bit c1, input int p1);
    return {10'h2AA, 4'(sel), c0, 8'(p0), c1, 8'(p1)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    tbl_we = 1'b1; tbl_waddr = 8'(addr); tbl_wdata = data;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic run(input logic [11:0] id, input bit exp_f, input logic [7:0] exp_r,
                     input int exp_c, input string req);
    int n = 0;
    bit got = 0;
    @(negedge clk);
    start = 1'b1; slave_id = id[11:8]; periph_num = id[7:0];
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    while (!got && n < 40) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      if (done) got = 1;
    end
    check({req, " cycles"}, n, exp_c);
    check({req, " found"}, found, exp_f);
    check({req, " result"}, result, exp_r);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; slave_id = '0; periph_num = '0;
    tbl_we = 1'b0; tbl_waddr = '0; tbl_wdata = '0;
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 found", found, 0);
    check("R1 result", result, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 busy after release", busy, 0);
    check("R1 result after release", result, 0);

    // R11: load the tree
    wr(0, mk(11, 1, 1, 0, 8'hA5));
    wr(1, mk(0, 0, 8'h10, 1, 2));
    wr(2, mk(13, 1, 3, 0, 8'hEE));
    wr(3, mk(8, 0, 8'h33, 1, 4));
    wr(4, mk(1, 1, 255, 1, 20));
    for (int i = 20; i < 30; i++) wr(i, mk(5, 1, i + 1, 1, i + 1));
    wr(30, mk(3, 0, 8'h5C, 1, 31));
    wr(31, mk(0, 0, 8'h99, 0, 8'h99));

    // R2 R3 R4 R5 R6 R7 R8: vector table
    for (int v = 0; v < 8; v++) begin
      run(VECS[v][25:14], VECS[v][13], VECS[v][12:5], int'(VECS[v][4:0]),
          $sformatf("R5/R6 vector %0d (R3 R4 R7 R8)", v));
    end

    // R10: start while busy is ignored; R2 busy rises
    begin
      int n = 1;
      bit got = 0;
      @(negedge clk);
      start = 1'b1; slave_id = 4'h0; periph_num = 8'h01;
      @(posedge clk);
      @(negedge clk);
      check("R2 busy after start", busy, 1);
      slave_id = 4'h8; periph_num = 8'h00;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      if (done) got = 1;
      while (!got && n < 40) begin
        @(posedge clk);
        @(negedge clk);
        n++;
        if (done) got = 1;
      end
      check("R10 cycles", n, 4);
      check("R10 result", result, 8'h33);
      @(negedge clk);
      check("R9 done single cycle", done, 0);
      check("R9 busy idle", busy, 0);
      repeat (3) @(negedge clk);
      check("R9 result held", result, 8'h33);
      check("R9 found held", found, 1);
    end

    // R11: rewrite node 0, write to 255 has no effect
    wr(0, mk(11, 1, 1, 0, 8'h5A));
    run(12'h800, 1'b1, 8'h5A, 1, "R11 rewrite node 0");
    wr(255, mk(0, 0, 8'h42, 0, 8'h42));
    run(12'h101, 1'b0, 8'h00, 6, "R11 write 255 ignored");
    run(12'h800, 1'b1, 8'h5A, 1, "R11 node 0 intact");
    wr(0, mk(11, 1, 1, 0, 8'hA5));
    run(12'h000, 1'b1, 8'h10, 2, "R11 restored tree");

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule